// File: doc/BRIEF.md
# Bus Switch Control Register Target

This block is the serial-bus target that sits behind a buffered four-way 2-wire bus switch. It listens on the upstream clock and data lines, answers to a 7-bit address whose low three bits come from strap inputs, and holds a single 8-bit control byte. The low bits of that byte switch each downstream channel on or off. The top bit selects the clock direction: either from the upstream port to the channels, or from the channels back upstream.

A host writes the byte in a one-byte write transaction. The new value is held in a staging register and reaches the switch fabric only when the bus STOP condition is seen. A repeated START or an address for another device throws the staged byte away. A read transaction returns the live value MSB first, with the unused positions reading as zero. The line inputs are brought into the block's clock domain through two-flop synchronizers. The block drives the data line only through an open-drain pull-low enable, and it changes that enable only while the clock line is low.

Top module: `swctl_target`

## Requirements
- R1: The block acknowledges only the 7-bit address binary 1110 followed by the three strap inputs (strap bit 2 first). Any other address gets no ACK and leaves the outputs unchanged.
- R2: In a write transaction (address byte with R/W bit = 0), the block pulls SDA low for the ACK bit after the address byte and again after the data byte. It changes its SDA pull-low enable only while synchronized SCL is low, or on a START or STOP.
- R3: In a read transaction (R/W bit = 1), the block ACKs the address and then shifts out the live register MSB first, one bit per SCL clock. It then releases SDA for the master's ACK/NACK bit.
- R4: A written byte changes the outputs only after the STOP condition. Before STOP, the outputs keep their old value.
- R5: After commit, register bits 3..0 drive channel enables 3..0 (1 = on) and bit 7 drives the direction output (1 = channels to upstream). Written bits 6..4 have no effect on any output.
- R6: A read returns bits 6..4 as zero, whatever was written to them.
- R7: While rst_n is low, and after it rises, the register is all zeros: all channels are off and the direction is forward.
- R8: If a repeated START arrives after a write data byte and before STOP, the staged byte is discarded and the live register is kept.
- R9: The block stays addressable over the upstream pins when bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset; clears the register |
| addr_strap | input | 3 | Low three address bits from strap pins |
| scl_in | input | 1 | Upstream SCL line level |
| sda_in | input | 1 | Upstream SDA line level (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 = pull upstream SDA low |
| chan_en | output | NUM_CH | Live channel enables |
| dir_rev | output | 1 | Live clock direction, 1 = channels to upstream |

## Verification
The bench looks inside the write path for the gap between the data ACK and the STOP. A design that commits at the ACK would change the channel enables too early, and a design that ignores the STOP would never change them. A repeated START before STOP is tested to show that a stale staged byte would otherwise leak into the live register. The bench sets the don't-care bits 6..4 and reads them back to catch a design that stores or echoes them. It also sends a mismatched address and changes the strap value, which exposes a design that ignores the strap bits or acknowledges every address.

// File: rtl/swctl_target.sv
module swctl_target #(
  parameter int          NUM_CH      = 4,
  parameter logic [3:0]  ADDR_FIXED  = 4'b1110,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr_strap,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NUM_CH-1:0] chan_en,
  output logic              dir_rev
);

  localparam int          REG_W   = 8;
  localparam int          DIR_BIT = REG_W - 1;
  localparam logic [REG_W-1:0] KEEP_MASK = (8'h1 << DIR_BIT) | ((8'h1 << NUM_CH) - 8'h1);
  localparam logic [3:0]  BITS    = 4'(REG_W);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_HOLD} st_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;
  st_t  st_q;
  logic [REG_W-1:0] live_q, stage_q, sh_q;
  logic stage_v, rw_q, pull_q;
  logic [3:0] cnt_q;
  logic [6:0] my_addr;

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign my_addr   = {ADDR_FIXED, addr_strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      live_q  <= '0;
      stage_q <= '0;
      sh_q    <= '0;
      stage_v <= 1'b0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (start_det) begin
      st_q    <= S_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
      stage_v <= 1'b0;
    end else if (stop_det) begin
      st_q    <= S_IDLE;
      pull_q  <= 1'b0;
      stage_v <= 1'b0;
      if (stage_v) live_q <= stage_q & KEEP_MASK;
    end else begin
      case (st_q)
        S_ADDR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[REG_W-2:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BITS) begin
            if (sh_q[7:1] == my_addr) begin
              rw_q   <= sh_q[0];
              pull_q <= 1'b1;
              st_q   <= S_AACK;
            end else begin
              st_q   <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q   <= live_q;
              pull_q <= ~live_q[DIR_BIT];
              st_q   <= S_RD;
            end else begin
              pull_q <= 1'b0;
              st_q   <= S_WR;
            end
          end
        end
        S_WR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[REG_W-2:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BITS) begin
            stage_q <= sh_q;
            stage_v <= 1'b1;
            pull_q  <= 1'b1;
            st_q    <= S_WACK;
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            pull_q <= 1'b0;
            st_q   <= S_HOLD;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BITS) begin
              pull_q <= 1'b0;
              st_q   <= S_HOLD;
            end else begin
              sh_q   <= {sh_q[REG_W-2:0], 1'b0};
              pull_q <= ~sh_q[REG_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull = pull_q;
  assign chan_en  = live_q[NUM_CH-1:0];
  assign dir_rev  = live_q[DIR_BIT];

endmodule

// File: rtl/swctl_target_chk.sv
module swctl_target_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_pull,
  input logic [NUM_CH-1:0] chan_en,
  input logic              dir_rev
);

  a_r4_commit_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dir_rev, chan_en}) |-> $past(stop_det));

  a_r2_pull_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_s));

  a_r2_pull_falls_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  a_r2_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset_clears: assert (chan_en == '0 && !dir_rev && !sda_pull);
    end
  end

endmodule

bind swctl_target swctl_target_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull), .chan_en(chan_en), .dir_rev(dir_rev)
);

// File: tb/swctl_target_bench.sv
module swctl_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap = 3'b101;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, dir_rev;
  logic [3:0] chan_en;
  logic sda_line;
  int checks = 0, errors = 0;

  assign sda_line = sda_m & ~sda_pull;

  swctl_target u_swctl_target (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(scl_m),
    .sda_in(sda_line), .sda_pull(sda_pull), .chan_en(chan_en), .dir_rev(dir_rev)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack, output logic [7:0] rd);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(b[i], s);
      rd[i] = s;
    end
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, input bit do_stop,
                        output logic ack_a, output logic ack_d);
    logic [7:0] junk;
    ack_d = 1'b0;
    bus_start();
    bus_byte({a, 1'b0}, ack_a, junk);
    if (ack_a) bus_byte(d, ack_d, junk);
    if (do_stop) bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, output logic ack, output logic [7:0] d);
    logic [7:0] junk;
    logic na;
    d = 8'h00;
    bus_start();
    bus_byte({a, 1'b1}, ack, junk);
    if (ack) bus_byte(8'hFF, na, d);
    bus_stop();
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] d;
    chk("R7 chan_en in reset", chan_en, 0);
    chk("R7 dir_rev in reset", dir_rev, 0);
    chk("R7 sda_pull in reset", sda_pull, 0);
    rst_n = 1'b1; wq();
    rd_txn({4'b1110, strap}, ack, d);
    chk("R3 read addr ack", ack, 1);
    chk("R7 read after reset", d, 8'h00);
  endtask

  task automatic t_write_commit();
    logic aa, ad;
    wr_txn({4'b1110, strap}, 8'h75, 0, aa, ad);
    chk("R2 address ack", aa, 1);
    chk("R2 data ack", ad, 1);
    chk("R4 before stop chan_en", chan_en, 0);
    chk("R4 before stop dir_rev", dir_rev, 0);
    bus_stop();
    chk("R5 chan_en after stop", chan_en, 4'h5);
    chk("R5 dir_rev after stop", dir_rev, 0);
  endtask

  task automatic t_read_masks();
    logic ack; logic [7:0] d;
    rd_txn({4'b1110, strap}, ack, d);
    chk("R6 read hides bits 6..4", d, 8'h05);
  endtask

  task automatic t_reverse();
    logic aa, ad, ack; logic [7:0] d;
    wr_txn({4'b1110, strap}, 8'hFA, 1, aa, ad);
    chk("R5 dir_rev set", dir_rev, 1);
    chk("R5 chan_en 1010", chan_en, 4'hA);
    rd_txn({4'b1110, strap}, ack, d);
    chk("R9 ack with bit7 set", ack, 1);
    chk("R3 R6 read with bit7", d, 8'h8A);
    wr_txn({4'b1110, strap}, 8'h03, 1, aa, ad);
    chk("R9 write with bit7 set", {dir_rev, chan_en}, 5'h03);
  endtask

  task automatic t_wrong_addr();
    logic aa, ad;
    wr_txn({4'b1110, 3'b010}, 8'h0C, 1, aa, ad);
    chk("R1 no ack wrong strap", aa, 0);
    chk("R1 outputs kept", {dir_rev, chan_en}, 5'h03);
    wr_txn(7'h3D, 8'h0C, 1, aa, ad);
    chk("R1 no ack wrong prefix", aa, 0);
    strap = 3'b010; wq();
    wr_txn({4'b1110, 3'b010}, 8'h0C, 1, aa, ad);
    chk("R1 ack after strap change", aa, 1);
    chk("R1 new value", {dir_rev, chan_en}, 5'h0C);
  endtask

  task automatic t_rep_start();
    logic aa, ad, ack; logic [7:0] d;
    wr_txn({4'b1110, strap}, 8'h8F, 0, aa, ad);
    chk("R8 staged data ack", ad, 1);
    rd_txn({4'b1110, strap}, ack, d);
    chk("R8 read after rep start", d, 8'h0C);
    chk("R8 outputs kept", {dir_rev, chan_en}, 5'h0C);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst_n = 1'b0; wq();
    chk("R7 reset clears enables", chan_en, 0);
    rst_n = 1'b1; wq();
    chk("R7 dir after reset", dir_rev, 0);
  endtask

  initial begin
    wq();
    t_reset();
    t_write_commit();
    t_read_masks();
    t_reverse();
    t_wrong_addr();
    t_rep_start();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule